// File: doc/BRIEF.md
# DMA Trigger Request Selector

This block sits in front of a four-channel DMA engine and decides when each channel is asked to start a transfer. Every channel owns an 8-bit control register. Its low six bits name one of up to 63 peripheral interrupt lines as the channel's start trigger. Its top bit is a sticky request flag that software can read and can only clear.

A single-cycle pulse on the selected interrupt line raises the flag. The flag stays raised until the DMA engine acknowledges the request or software writes a zero to it. The DMA engine also drives a per-channel enable. While the enable is low, a raised flag is held but not issued on the request output, so a trigger that arrives while the channel is disabled, suspended or terminated is not lost.

Registers are reached over a simple bus. The bus offers whole-byte writes and a single-bit write that touches only the flag. Reads are combinational.

Top module: `dma_trig_sel`

## Requirements
- R1: After reset, all four registers read 0x00 and every bit of `req_o` is 0.
- R2: Channel k's register sits at address 0x810 + 2k (k = 0..3). On a read, bit 7 is the request flag, bits 5:0 are the source code, and bit 6 always reads 0.
- R3: A byte write (`wr_i`) to a mapped address stores `wdata_i[5:0]` as the source code. `wdata_i[6]` is discarded.
- R4: Writing 0 to bit 7, by either a byte write or a single-bit write, clears the flag. Writing 1 to bit 7 leaves the flag unchanged.
- R5: A single-bit write (`bit_wr_i`) changes only the flag. The source code is kept.
- R6: With source code s nonzero, a pulse on `irq_i[s-1]` sets the flag by the next clock edge. Code 0 and pulses on unselected lines never set the flag.
- R7: `req_o[k]` is 1 exactly when channel k's flag is set and `ch_en_i[k]` is 1. A flag set while the enable is low is held.
- R8: A pulse on `dma_ack_i[k]` clears channel k's flag at the next edge.
- R9: A trigger in the same cycle as an acknowledge or a software clear leaves the flag set.
- R10: Reads from unmapped addresses (odd addresses, or addresses outside the four slots) return 0x00. Writes to unmapped addresses change no register.
- R11: Channels are independent. A pulse sets exactly the flags of those channels whose source code selects that line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | 63 | Peripheral interrupt pulses; bit j is selected by code j+1 |
| addr_i | input | 12 | Register address |
| wr_i | input | 1 | Byte write strobe |
| bit_wr_i | input | 1 | Single-bit write strobe on bit 7 |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i` (combinational) |
| dma_ack_i | input | 4 | Per-channel request acknowledge from the DMA engine |
| ch_en_i | input | 4 | Per-channel enable from the DMA engine |
| req_o | output | 4 | Per-channel transfer request |

## Verification
A flag that is stuck, set by the wrong line, or lost shows up on `rdata_o` at the first read after the edge that should have moved it. With the channel enabled, the same fault shows on `req_o` one cycle after the trigger. A corrupted source code is exposed by the next read of that register, and indirectly by the line-by-line sweep, where a wrong code makes a flag rise on the wrong pulse. Priority faults between set and clear show as a flag reading 0 in the cycle after a combined trigger and acknowledge.

// File: rtl/dts_pkg.sv
package dts_pkg;
  localparam int REG_W    = 8;
  localparam int SEL_W    = 6;
  localparam int FLAG_BIT = 7;
  localparam int RSV_BIT  = 6;
endpackage

// File: rtl/dts_addr_dec.sv
module dts_addr_dec #(
  parameter int          N_CH   = 4,
  parameter int          ADDR_W = 12,
  parameter logic [11:0] BASE   = 12'h810
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [N_CH-1:0]   hit_o
);
  localparam int STRIDE = 2;

  for (genvar k = 0; k < N_CH; k++) begin : g_slot
    localparam logic [ADDR_W-1:0] SLOT = ADDR_W'(BASE) + ADDR_W'(k * STRIDE);
    assign hit_o[k] = (addr_i == SLOT);
  end
endmodule

// File: rtl/dts_src_mux.sv
module dts_src_mux #(
  parameter int N_SRC = 63,
  parameter int SEL_W = 6
) (
  input  logic [SEL_W-1:0] sel_i,
  input  logic [N_SRC-1:0] irq_i,
  output logic             trig_o
);
  // code 0 selects nothing; code k selects line k-1
  always_comb begin
    trig_o = 1'b0;
    for (int k = 1; k <= N_SRC; k++) begin
      if (sel_i == SEL_W'(k)) trig_o = irq_i[k-1];
    end
  end
endmodule

// File: rtl/dts_chan.sv
module dts_chan
  import dts_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic             bit_en_i,
  input  logic [REG_W-1:0] wdata_i,
  input  logic             trig_i,
  input  logic             ack_i,
  input  logic             en_i,
  output logic             flag_o,
  output logic [SEL_W-1:0] sel_o,
  output logic             req_o
);
  logic             flag_q, flag_d;
  logic [SEL_W-1:0] sel_q;
  logic             sw_clr;

  // only a zero in the flag position clears; a one is ignored
  assign sw_clr = (wr_en_i | bit_en_i) & ~wdata_i[FLAG_BIT];

  always_comb begin
    flag_d = flag_q;
    if (ack_i || sw_clr) flag_d = 1'b0;
    if (trig_i)          flag_d = 1'b1;  // set wins
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= 1'b0;
      sel_q  <= '0;
    end else begin
      flag_q <= flag_d;
      if (wr_en_i) sel_q <= wdata_i[SEL_W-1:0];
    end
  end

  assign flag_o = flag_q;
  assign sel_o  = sel_q;
  assign req_o  = flag_q & en_i;
endmodule

// File: rtl/dma_trig_sel.sv
module dma_trig_sel
  import dts_pkg::*;
#(
  parameter int          N_CH   = 4,
  parameter int          N_SRC  = 63,
  parameter int          ADDR_W = 12,
  parameter logic [11:0] BASE   = 12'h810
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_SRC-1:0]  irq_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic              bit_wr_i,
  input  logic [REG_W-1:0]  wdata_i,
  output logic [REG_W-1:0]  rdata_o,
  input  logic [N_CH-1:0]   dma_ack_i,
  input  logic [N_CH-1:0]   ch_en_i,
  output logic [N_CH-1:0]   req_o
);
  logic [N_CH-1:0]            hit;
  logic [N_CH-1:0]            trig;
  logic [N_CH-1:0]            flag_q;
  logic [N_CH-1:0][SEL_W-1:0] sel_q;

  dts_addr_dec #(
    .N_CH  (N_CH),
    .ADDR_W(ADDR_W),
    .BASE  (BASE)
  ) u_dec (
    .addr_i(addr_i),
    .hit_o (hit)
  );

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    dts_src_mux #(
      .N_SRC(N_SRC),
      .SEL_W(SEL_W)
    ) u_mux (
      .sel_i (sel_q[c]),
      .irq_i (irq_i),
      .trig_o(trig[c])
    );

    dts_chan u_chan (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .wr_en_i (wr_i & hit[c]),
      .bit_en_i(bit_wr_i & hit[c]),
      .wdata_i (wdata_i),
      .trig_i  (trig[c]),
      .ack_i   (dma_ack_i[c]),
      .en_i    (ch_en_i[c]),
      .flag_o  (flag_q[c]),
      .sel_o   (sel_q[c]),
      .req_o   (req_o[c])
    );
  end

  // reserved bit always reads zero; unmapped reads return zero
  always_comb begin
    rdata_o = '0;
    for (int c = 0; c < N_CH; c++) begin
      if (hit[c]) begin
        rdata_o[FLAG_BIT]    = flag_q[c];
        rdata_o[SEL_W-1:0]   = sel_q[c];
      end
    end
  end
endmodule

// File: rtl/dts_chk.sv
module dts_chk
  import dts_pkg::*;
#(
  parameter int N_CH  = 4,
  parameter int N_SRC = 63
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic [N_SRC-1:0]           irq_i,
  input logic                       wr_i,
  input logic                       bit_wr_i,
  input logic [N_CH-1:0]            dma_ack_i,
  input logic [N_CH-1:0]            ch_en_i,
  input logic [N_CH-1:0]            req_o,
  input logic [REG_W-1:0]           rdata_o,
  input logic [N_CH-1:0]            flag_i,
  input logic [N_CH-1:0][SEL_W-1:0] sel_i
);
  logic [N_SRC:0] ext;
  assign ext = {irq_i, 1'b0};

  assert_rsv_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_o[RSV_BIT] == 1'b0);

  for (genvar c = 0; c < N_CH; c++) begin : g_c
    logic sel_hit;
    assign sel_hit = (sel_i[c] != '0) && ext[sel_i[c]];

    assert_set_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      sel_hit |=> flag_i[c]);

    assert_rise_needs_code_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(flag_i[c]) |-> $past(sel_i[c] != '0));

    assert_gate_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !ch_en_i[c] |-> !req_o[c]);

    assert_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flag_i[c] && !dma_ack_i[c] && !wr_i && !bit_wr_i) |=> flag_i[c]);

    assert_ack_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (dma_ack_i[c] && !sel_hit) |=> !flag_i[c]);
  end
endmodule

bind dma_trig_sel dts_chk #(
  .N_CH (N_CH),
  .N_SRC(N_SRC)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .irq_i    (irq_i),
  .wr_i     (wr_i),
  .bit_wr_i (bit_wr_i),
  .dma_ack_i(dma_ack_i),
  .ch_en_i  (ch_en_i),
  .req_o    (req_o),
  .rdata_o  (rdata_o),
  .flag_i   (flag_q),
  .sel_i    (sel_q)
);

// File: tb/sim_dma_trig_sel.sv
`timescale 1ns/1ps
module sim_dma_trig_sel;
  localparam int N_CH  = 4;
  localparam int N_SRC = 63;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [N_SRC-1:0] irq = '0;
  logic [11:0]      addr = '0;
  logic             wr = 1'b0;
  logic             bwr = 1'b0;
  logic [7:0]       wdata = '0;
  logic [7:0]       rdata;
  logic [N_CH-1:0]  ack = '0;
  logic [N_CH-1:0]  en = '0;
  logic [N_CH-1:0]  req;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  dma_trig_sel u0 (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .irq_i    (irq),
    .addr_i   (addr),
    .wr_i     (wr),
    .bit_wr_i (bwr),
    .wdata_i  (wdata),
    .rdata_o  (rdata),
    .dma_ack_i(ack),
    .ch_en_i  (en),
    .req_o    (req)
  );

  function automatic logic [11:0] reg_addr(int c);
    return 12'h810 + 12'(2 * c);
  endfunction

  task automatic chk(string req_tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%02h expected=0x%02h", req_tag, act, exp);
    end
  endtask

  task automatic bus_wr(logic [11:0] a, logic [7:0] d, bit single);
    @(negedge clk);
    addr = a; wdata = d; wr = !single; bwr = single;
    @(negedge clk);
    wr = 1'b0; bwr = 1'b0;
  endtask

  task automatic bus_rd(logic [11:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic pulse(int j);
    @(negedge clk);
    irq[j] = 1'b1;
    @(negedge clk);
    irq = '0;
  endtask

  initial begin
    logic [7:0] rd;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    for (int c = 0; c < N_CH; c++) begin
      bus_rd(reg_addr(c), rd);
      chk("R1", rd, 8'h00);
    end
    chk("R1", {4'h0, req}, 8'h00);

    // R2 R3: byte write sweep, bit 6 dropped, bit 7 = 1 ignored on clear flag
    for (int c = 0; c < N_CH; c++) begin
      for (int v = 0; v < 256; v += 37) begin
        bus_wr(reg_addr(c), 8'(v) | 8'h80, 1'b0);
        bus_rd(reg_addr(c), rd);
        chk("R3", rd, 8'(v) & 8'h3F);
        chk("R2", {7'h0, rd[6]}, 8'h00);
      end
    end

    // R6: every code against every line, per channel
    en = '1;
    for (int c = 0; c < N_CH; c++) begin
      for (int code = 0; code < 64; code++) begin
        bus_wr(reg_addr(c), 8'(code), 1'b0);
        for (int j = 0; j < N_SRC; j++) begin
          logic exp_set;
          exp_set = (code != 0) && (j == code - 1);
          pulse(j);
          bus_rd(reg_addr(c), rd);
          chk("R6", {7'h0, rd[7]}, {7'h0, exp_set});
          chk("R6", {7'h0, req[c]}, {7'h0, exp_set});
          if (rd[7]) bus_wr(reg_addr(c), 8'h00, 1'b1);
        end
      end
      bus_wr(reg_addr(c), 8'h00, 1'b0);
    end

    // R4 R5: write-one keeps flag, write-zero clears, single-bit keeps code
    bus_wr(reg_addr(1), 8'h05, 1'b0);
    pulse(4);
    bus_wr(reg_addr(1), 8'h85, 1'b0);
    bus_rd(reg_addr(1), rd);
    chk("R4", rd, 8'h85);
    bus_wr(reg_addr(1), 8'h80, 1'b1);
    bus_rd(reg_addr(1), rd);
    chk("R4", rd, 8'h85);
    bus_wr(reg_addr(1), 8'h3F, 1'b1);
    bus_rd(reg_addr(1), rd);
    chk("R5", rd, 8'h05);
    pulse(4);
    bus_wr(reg_addr(1), 8'h05, 1'b0);
    bus_rd(reg_addr(1), rd);
    chk("R4", rd, 8'h05);

    // R7: held while disabled, issued once enabled
    en = '0;
    pulse(4);
    bus_rd(reg_addr(1), rd);
    chk("R7", rd, 8'h85);
    chk("R7", {4'h0, req}, 8'h00);
    @(negedge clk);
    en = 4'b0010;
    #1;
    chk("R7", {4'h0, req}, 8'h02);

    // R8: acknowledge clears
    @(negedge clk);
    ack = 4'b0010;
    @(negedge clk);
    ack = '0;
    #1;
    chk("R8", {4'h0, req}, 8'h00);
    bus_rd(reg_addr(1), rd);
    chk("R8", rd, 8'h05);

    // R9: set beats ack and software clear
    @(negedge clk);
    ack = 4'b0010; irq[4] = 1'b1;
    @(negedge clk);
    ack = '0; irq = '0;
    bus_rd(reg_addr(1), rd);
    chk("R9", rd, 8'h85);
    @(negedge clk);
    addr = reg_addr(1); wdata = 8'h00; bwr = 1'b1; irq[4] = 1'b1;
    @(negedge clk);
    bwr = 1'b0; irq = '0;
    bus_rd(reg_addr(1), rd);
    chk("R9", rd, 8'h85);

    // R10: unmapped addresses
    bus_wr(12'h811, 8'h2A, 1'b0);
    bus_wr(12'h818, 8'h00, 1'b0);
    bus_wr(12'h80E, 8'h00, 1'b1);
    bus_wr(12'h813, 8'h00, 1'b1);
    bus_rd(reg_addr(1), rd);
    chk("R10", rd, 8'h85);
    bus_rd(reg_addr(0), rd);
    chk("R10", rd, 8'h00);
    bus_rd(12'h811, rd);
    chk("R10", rd, 8'h00);
    bus_rd(12'h818, rd);
    chk("R10", rd, 8'h00);
    bus_rd(12'h010, rd);
    chk("R10", rd, 8'h00);

    // R11: independent channels
    bus_wr(reg_addr(1), 8'h00, 1'b1);
    bus_wr(reg_addr(0), 8'h01, 1'b0);
    bus_wr(reg_addr(1), 8'h02, 1'b0);
    bus_wr(reg_addr(2), 8'h03, 1'b0);
    bus_wr(reg_addr(3), 8'h03, 1'b0);
    en = '1;
    pulse(2);
    #1;
    chk("R11", {4'h0, req}, 8'h0C);
    pulse(0);
    #1;
    chk("R11", {4'h0, req}, 8'h0D);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule